// File: doc/BRIEF.md
# ULPI Transceiver Control Register Bank

This block holds the two transceiver-side control registers that a link reaches over the ULPI register protocol. The first register picks the line speed, the termination and the transmit encoding style, and it carries two self-managed bits: a transceiver-reset request and an active-low power-state bit. The second register holds the flags that switch the transceiver into alternative link interfaces. A plain register port stands in for the decoded ULPI register access: an address, write data, a write strobe, and combinational read data.

Each register sits at three consecutive addresses. The first address loads the value, the second ORs the data into it, and the third clears every bit that is 1 in the data. All three addresses read back the current value. Hardware also updates the register. When the link sets the reset bit, the block holds its bus-direction request and a core-reset pulse for a fixed number of cycles. It then drops both, clears the bit on its own, and issues a one-cycle request for a receive-status update. When the link clears the power bit, the block reports low power until the link raises STP, and then it sets the bit back on its own.

Top module: `ulpiPhyCtlBank`

## Requirements
- R1: After reset, addresses 0x04, 0x05 and 0x06 read 0x41. Addresses 0x07, 0x08 and 0x09 read 0x00. Every other address reads 0x00.
- R2: A write to 0x04 or 0x07 loads the data into the writable bits of that register. The writable bits are 6 and 4..0 for the first register and 7, 6, 5, 3 and 1 for the second.
- R3: A write to 0x05 or 0x08 ORs the data into the writable bits of that register.
- R4: A write to 0x06 or 0x09 clears each writable bit of that register whose data bit is 1.
- R5: Bit 7 of the first register and bits 4, 2 and 0 of the second ignore every write, set and clear, and always read 0.
- R6: The decoded outputs follow the first register: opMode is bits 4..3 (0 normal, 1 non-driving, 2 no stuffing or NRZI, 3 no automatic SYNC or EOP), termSel is bit 2, and xcvrSel is bits 1..0 (0 HS, 1 FS, 2 LS, 3 FS with LS preamble). The interface flags follow the second register: bit 7 protDisable, bit 6 indPassthru, bit 5 indComplement, bit 3 clkSuspendN, bit 1 serial3Pin.
- R7: When bit 5 (the reset bit) becomes 1, dirReq and coreRst rise at the next clock edge and stay high for exactly RST_CYCLES cycles. The other register bits keep their values.
- R8: At the edge where the reset pulse ends, dirReq and coreRst fall and the reset bit reads 0. rxCmdUpdate is then high for exactly that one cycle.
- R9: The link cannot clear the reset bit. A set of the reset bit is ignored while a reset sequence, including its update cycle, is in progress.
- R10: Clearing bit 6 (the power bit) makes lowPower read 1 from the next cycle on.
- R11: While lowPower is 1, stp high at a clock edge sets bit 6 back to 1 and drops lowPower. stp has no effect while lowPower is 0.
- R12: A hardware update of bit 5 or bit 6 takes priority over a link access to that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe |
| stp | input | 1 | Link stop signal, used to exit low power |
| regRdData | output | 8 | Read data for regAddr |
| opMode | output | 2 | Transmit encoding style |
| termSel | output | 1 | Termination select |
| xcvrSel | output | 2 | Transceiver speed select |
| protDisable | output | 1 | Interface protection disable |
| indPassthru | output | 1 | Indicator passthrough |
| indComplement | output | 1 | Indicator complement |
| clkSuspendN | output | 1 | Active-low clock suspend |
| serial3Pin | output | 1 | Three-pin serial mode enable |
| dirReq | output | 1 | Bus direction request during a transceiver reset |
| coreRst | output | 1 | Digital core reset pulse |
| lowPower | output | 1 | Low-power mode flag |
| rxCmdUpdate | output | 1 | One-cycle receive-status update request |

## Verification
The bench builds the block with RST_CYCLES set to 3. This keeps each reset sequence short, so the bench can count the cycles of the pulse and land link accesses on its first, middle and last cycles and on its update cycle. Register access is swept over all 256 data values for each of the three alias addresses of both registers, and read back over all 64 addresses. The expected values are computed with mask arithmetic.

// File: rtl/ulpiCtlPkg.sv
package ulpiCtlPkg;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_LOAD,
    ACC_SET,
    ACC_CLR
  } accKind_t;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic clrReset;     // reset sequence finished
    logic setSuspendM;  // low-power exit on stp
    logic lockReset;    // sequence running, link sets of the reset bit ignored
  } hwStrobe_t;

  localparam int FC_SUSPENDM = 6;
  localparam int FC_RESET    = 5;
  localparam logic [7:0] FC_LINK_MASK = 8'h5F;
  localparam logic [7:0] FC_INIT      = 8'h41;
  localparam logic [7:0] IC_LINK_MASK = 8'hEA;
  localparam logic [7:0] IC_INIT      = 8'h00;

  function automatic logic [7:0] applyAccess(accKind_t kind, logic [7:0] cur, logic [7:0] data);
    logic [7:0] res;
    unique case (kind)
      ACC_LOAD: res = data;
      ACC_SET:  res = cur | data;
      ACC_CLR:  res = cur & ~data;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/ulpiRegDatapath.sv
module ulpiRegDatapath
  import ulpiCtlPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] FUNC_BASE = 6'h04,
  parameter logic [ADDR_W-1:0] INTF_BASE = 6'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              regWrEn,
  input  hwStrobe_t         hw,
  output logic [7:0]        regRdData,
  output logic [7:0]        funcQ,
  output logic [7:0]        intfQ
);

  localparam int NUM_REGS = 2;
  localparam int ALIASES  = 3;

  logic [NUM_REGS-1:0] hit;
  accKind_t            kind [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gDecode
      localparam logic [ADDR_W-1:0] BASE = (g == 0) ? FUNC_BASE : INTF_BASE;
      logic [ADDR_W-1:0] offs;
      assign offs   = regAddr - BASE;
      assign hit[g] = (regAddr >= BASE) && (offs < ADDR_W'(ALIASES));
      always_comb begin
        kind[g] = ACC_NONE;
        if (regWrEn && hit[g]) begin
          unique case (offs[1:0])
            2'd0:    kind[g] = ACC_LOAD;
            2'd1:    kind[g] = ACC_SET;
            default: kind[g] = ACC_CLR;
          endcase
        end
      end
    end
  endgenerate

  logic [7:0] funcLink, funcNext, intfNext;

  always_comb begin
    funcLink = applyAccess(kind[0], funcQ, regWrData);
    funcNext = funcLink & FC_LINK_MASK;
    funcNext[FC_SUSPENDM] = hw.setSuspendM ? 1'b1 : funcLink[FC_SUSPENDM];
    funcNext[FC_RESET]    = hw.clrReset ? 1'b0
                          : (funcQ[FC_RESET] | (funcLink[FC_RESET] & ~hw.lockReset));
    intfNext = applyAccess(kind[1], intfQ, regWrData) & IC_LINK_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcQ <= FC_INIT;
      intfQ <= IC_INIT;
    end else begin
      funcQ <= funcNext;
      intfQ <= intfNext;
    end
  end

  always_comb begin
    if (hit[0])      regRdData = funcQ;
    else if (hit[1]) regRdData = intfQ;
    else             regRdData = 8'h00;
  end

endmodule

// File: rtl/ulpiRegControl.sv
module ulpiRegControl
  import ulpiCtlPkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      resetBit,
  input  logic      suspendMBit,
  input  logic      stp,
  output hwStrobe_t hw,
  output logic      dirReq,
  output logic      coreRst,
  output logic      lowPower,
  output logic      rxCmdUpdate
);

  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BUSY, SEQ_NOTIFY} seqState_t;

  seqState_t  seqState;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      cnt      <= '0;
    end else begin
      unique case (seqState)
        SEQ_IDLE: if (resetBit) begin
          seqState <= SEQ_BUSY;
          cnt      <= CNT_W'(RST_CYCLES - 1);
        end
        SEQ_BUSY: begin
          if (cnt == '0) seqState <= SEQ_NOTIFY;
          else           cnt <= cnt - 1'b1;
        end
        default: seqState <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    hw.clrReset    = (seqState == SEQ_BUSY) && (cnt == '0);
    hw.lockReset   = (seqState != SEQ_IDLE);
    hw.setSuspendM = stp && !suspendMBit;
  end

  assign dirReq      = (seqState == SEQ_BUSY);
  assign coreRst     = (seqState == SEQ_BUSY);
  assign rxCmdUpdate = (seqState == SEQ_NOTIFY);
  assign lowPower    = !suspendMBit;

endmodule

// File: rtl/ulpiPhyCtlBank.sv
module ulpiPhyCtlBank
  import ulpiCtlPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              regWrEn,
  input  logic              stp,
  output logic [7:0]        regRdData,
  output logic [1:0]        opMode,
  output logic              termSel,
  output logic [1:0]        xcvrSel,
  output logic              protDisable,
  output logic              indPassthru,
  output logic              indComplement,
  output logic              clkSuspendN,
  output logic              serial3Pin,
  output logic              dirReq,
  output logic              coreRst,
  output logic              lowPower,
  output logic              rxCmdUpdate
);

  hwStrobe_t  hw;
  logic [7:0] funcQ, intfQ;

  ulpiRegDatapath #(
    .ADDR_W(ADDR_W),
    .FUNC_BASE(ADDR_W'(4)),
    .INTF_BASE(ADDR_W'(7))
  ) uDatapath (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .hw(hw), .regRdData(regRdData),
    .funcQ(funcQ), .intfQ(intfQ)
  );

  ulpiRegControl #(.RST_CYCLES(RST_CYCLES)) uControl (
    .clk(clk), .rstN(rstN), .resetBit(funcQ[FC_RESET]),
    .suspendMBit(funcQ[FC_SUSPENDM]), .stp(stp), .hw(hw),
    .dirReq(dirReq), .coreRst(coreRst), .lowPower(lowPower),
    .rxCmdUpdate(rxCmdUpdate)
  );

  assign opMode        = funcQ[4:3];
  assign termSel       = funcQ[2];
  assign xcvrSel       = funcQ[1:0];
  assign protDisable   = intfQ[7];
  assign indPassthru   = intfQ[6];
  assign indComplement = intfQ[5];
  assign clkSuspendN   = intfQ[3];
  assign serial3Pin    = intfQ[1];

endmodule

// File: rtl/ulpiPhyCtlBank_chk.sv
module ulpiPhyCtlBank_chk #(
  parameter int ADDR_W = 6,
  parameter int RST_CYCLES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regRdData,
  input logic              stp,
  input logic              dirReq,
  input logic              coreRst,
  input logic              lowPower,
  input logic              rxCmdUpdate
);

  localparam int PW = $clog2(RST_CYCLES + 2);
  logic [PW-1:0] pulseLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pulseLen <= '0;
    else if (coreRst) pulseLen <= pulseLen + 1'b1;
    else              pulseLen <= '0;
  end

  // R7
  core_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |-> dirReq);

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseLen <= PW'(RST_CYCLES));

  // R8
  update_after_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dirReq) |-> rxCmdUpdate);

  // R8
  update_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCmdUpdate |=> !rxCmdUpdate);

  // R8
  update_not_during_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxCmdUpdate && dirReq));

  // R11
  wake_on_stp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowPower && stp) |=> !lowPower);

  // R5
  func_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= ADDR_W'(4) && regAddr <= ADDR_W'(6)) |-> !regRdData[7]);

  // R5
  intf_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= ADDR_W'(7) && regAddr <= ADDR_W'(9))
      |-> (regRdData[4] == 1'b0 && regRdData[2] == 1'b0 && regRdData[0] == 1'b0));

endmodule

bind ulpiPhyCtlBank ulpiPhyCtlBank_chk #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData), .stp(stp),
  .dirReq(dirReq), .coreRst(coreRst), .lowPower(lowPower), .rxCmdUpdate(rxCmdUpdate)
);

// File: tb/ulpiPhyCtlBank_test.sv
module ulpiPhyCtlBank_test;

  localparam int R = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       regWrEn = 1'b0;
  logic       stp = 1'b0;
  logic [7:0] regRdData;
  logic [1:0] opMode, xcvrSel;
  logic termSel, protDisable, indPassthru, indComplement, clkSuspendN, serial3Pin;
  logic dirReq, coreRst, lowPower, rxCmdUpdate;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ulpiPhyCtlBank #(.ADDR_W(6), .RST_CYCLES(R)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .stp(stp), .regRdData(regRdData), .opMode(opMode),
    .termSel(termSel), .xcvrSel(xcvrSel), .protDisable(protDisable),
    .indPassthru(indPassthru), .indComplement(indComplement),
    .clkSuspendN(clkSuspendN), .serial3Pin(serial3Pin), .dirReq(dirReq),
    .coreRst(coreRst), .lowPower(lowPower), .rxCmdUpdate(rxCmdUpdate)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // called just after a negedge; returns at the following negedge
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic checkFuncOuts(input string req, input logic [7:0] f);
    chk(req, {6'b0, opMode}, {6'b0, f[4:3]});
    chk(req, {7'b0, termSel}, {7'b0, f[2]});
    chk(req, {6'b0, xcvrSel}, {6'b0, f[1:0]});
  endtask

  task automatic checkIntfOuts(input string req, input logic [7:0] v);
    chk(req, {protDisable, indPassthru, indComplement, 1'b0, clkSuspendN, 1'b0, serial3Pin, 1'b0},
        v & 8'hEA);
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] v, p, dd;
    int nDir, nUpd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values over every address
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), v);
      if (a >= 4 && a <= 6)      chk("R1", v, 8'h41);
      else if (a >= 7 && a <= 9) chk("R1", v, 8'h00);
      else                       chk("R1", v, 8'h00);
    end
    chk("R1", {dirReq, coreRst, lowPower, rxCmdUpdate}, 8'h00);
    checkFuncOuts("R6", 8'h41);
    @(negedge clk);

    // R2 R3 R4 R5 R6: interface register sweep
    for (int d = 0; d < 256; d++) begin
      p = 8'((d * 37 + 11) & 255);
      wr(6'h07, 8'(d));
      rd(6'h07, v); chk("R2", v, 8'(d) & 8'hEA);
      checkIntfOuts("R6", 8'(d));
      wr(6'h07, p);
      wr(6'h08, 8'(d));
      rd(6'h08, v); chk("R3", v, (p | 8'(d)) & 8'hEA);
      wr(6'h07, p);
      wr(6'h09, 8'(d));
      rd(6'h09, v); chk("R4", v, (p & ~8'(d)) & 8'hEA);
    end

    // R2 R3 R4 R5 R6: function register sweep, keeping bit 6 set and bit 5 clear
    for (int d = 0; d < 256; d++) begin
      p  = 8'(((d * 53 + 7) & 8'h1F) | 8'h40);
      dd = (8'(d) & 8'h9F) | 8'h40;
      wr(6'h04, dd);
      rd(6'h04, v); chk("R2", v, dd & 8'h5F);
      checkFuncOuts("R6", dd);
      chk("R5", {7'b0, dirReq}, 8'h00);
      wr(6'h04, p);
      wr(6'h05, 8'(d) & 8'h9F);
      rd(6'h05, v); chk("R3", v, (p | (8'(d) & 8'h9F)) & 8'h5F);
      wr(6'h04, p);
      wr(6'h06, 8'(d) & 8'h9F);
      rd(6'h06, v); chk("R4", v, (p & ~(8'(d) & 8'h9F)) & 8'h5F);
      checkFuncOuts("R6", (p & ~(8'(d) & 8'h9F)));
    end

    // R7 R8 R9: reset sequence with link accesses during it
    wr(6'h04, 8'h5A);
    wr(6'h07, 8'hA2);
    wr(6'h05, 8'h20);
    chk("R7", {dirReq, coreRst}, 8'h00);
    rd(6'h04, v); chk("R7", v, 8'h7A);
    for (int i = 0; i < R; i++) begin
      @(negedge clk);
      regWrEn = 1'b0;
      chk("R7", {6'b0, dirReq, coreRst}, 8'h03);
      rd(6'h04, v); chk("R9", v, 8'h7A);
      if (i == 0) begin regAddr = 6'h05; regWrData = 8'h20; regWrEn = 1'b1; end
      if (i == 1) begin regAddr = 6'h06; regWrData = 8'h20; regWrEn = 1'b1; end
      if (i == 2) begin regAddr = 6'h05; regWrData = 8'h20; regWrEn = 1'b1; end
    end
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R8", {5'b0, dirReq, coreRst, rxCmdUpdate}, 8'h01);
    rd(6'h04, v); chk("R8", v, 8'h5A);
    // set during the update cycle must be ignored
    regAddr = 6'h05; regWrData = 8'h20; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R8", {7'b0, rxCmdUpdate}, 8'h00);
    for (int i = 0; i < R + 2; i++) begin
      chk("R9", {6'b0, dirReq, rxCmdUpdate}, 8'h00);
      rd(6'h04, v); chk("R9", v, 8'h5A);
      @(negedge clk);
    end
    checkFuncOuts("R7", 8'h5A);
    checkIntfOuts("R7", 8'hA2);

    // R7 R8: load alias starts a sequence; count pulse and update cycles
    wr(6'h04, 8'h7A);
    nDir = 0; nUpd = 0;
    for (int i = 0; i < R + 6; i++) begin
      @(negedge clk);
      if (dirReq) nDir++;
      if (rxCmdUpdate) nUpd++;
    end
    chk("R7", 8'(nDir), 8'(R));
    chk("R8", 8'(nUpd), 8'd1);
    rd(6'h06, v); chk("R8", v, 8'h5A);

    // R11: stp without low power has no effect
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
    rd(6'h04, v); chk("R11", v, 8'h5A);
    chk("R11", {7'b0, lowPower}, 8'h00);

    // R10 R11: enter low power, leave on stp
    wr(6'h06, 8'h40);
    chk("R10", {7'b0, lowPower}, 8'h01);
    rd(6'h04, v); chk("R10", v, 8'h1A);
    @(negedge clk);
    chk("R10", {7'b0, lowPower}, 8'h01);
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
    chk("R11", {7'b0, lowPower}, 8'h00);
    rd(6'h04, v); chk("R11", v, 8'h5A);

    // R12: stp exit wins over a same-cycle link clear of bit 6
    wr(6'h06, 8'h40);
    chk("R12", {7'b0, lowPower}, 8'h01);
    stp = 1'b1; regAddr = 6'h06; regWrData = 8'h40; regWrEn = 1'b1;
    @(negedge clk);
    stp = 1'b0; regWrEn = 1'b0;
    chk("R12", {7'b0, lowPower}, 8'h00);
    rd(6'h05, v); chk("R12", v, 8'h5A);

    // R12: hardware clear of bit 5 wins over a same-cycle link set (last busy cycle)
    wr(6'h05, 8'h20);
    for (int i = 0; i < R; i++) begin
      @(negedge clk);
      regWrEn = 1'b0;
      if (i == R - 1) begin regAddr = 6'h04; regWrData = 8'h7A; regWrEn = 1'b1; end
    end
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R12", {6'b0, dirReq, rxCmdUpdate}, 8'h01);
    rd(6'h04, v); chk("R12", v, 8'h5A);

    done = 1'b1;
    report();
  end

endmodule